// File: doc/BRIEF.md
# Access-List Address-Space Resolver

This block turns an access-register token into the 64-bit control word that designates an address space. A zero register number and the two reserved token values are resolved straight from the primary and secondary control registers. Any other token starts a chain of dependent memory reads. The chain covers a list designation word, a two-doubleword list entry, a three-doubleword second-level table entry and, when needed, one byte of an authority table. Each returned word is validated before the next read is issued.

The resolver is started with a one-cycle pulse while idle. It reports completion with a one-cycle `done_o` pulse. At that point `fault_o` holds either zero, with the resolved word on `cw_o`, or a 4-bit fault code, with `cw_o` cleared. Memory is reached through a single-outstanding request/acknowledge read port. Each read returns the big-endian doubleword that contains the requested byte address. The address translation that later uses the control word lies outside this block.

Top module: `aspace_resolver`

## Requirements
- R1: A start with register number 0, or with token 0, completes on the next cycle with fault 0 and `cw_o` equal to `cr_prim_i`. A start with a nonzero register and token 1 does the same with `cr_sec_i`. Neither case issues a memory read.
- R2: Otherwise, if any of token bits 31:25 is set, the request completes with fault code 1 and issues no read.
- R3: The first read address is taken from the low 32 bits of `cr_dsg_priv_i` when token bit 24 is 1, or of `cr_dsg_pub_i` when it is 0. That value is ANDed with 0x7FFFFFC0 and 16 is added. The designation word is bits 63:32 of the returned doubleword: origin in bits 30:7, length in bits 6:0.
- R4: Let the entry number be token bits 15:0. If the entry number divided by 8 exceeds the length, the result is fault 2. Otherwise, if origin×128 + entry×16 exceeds 0x7FFFFFFF, the result is fault 3.
- R5: The list entry is read as two doublewords, at that sum and at sum+8. If bit 63 of the first doubleword is set, the result is fault 2. Otherwise, if its bits 55:48 differ from token bits 23:16, the result is fault 4.
- R6: The second-level entry is read as three doublewords starting at (bits 62:38 of the second list-entry doubleword)×64. If bit 63 of its first doubleword is set, the result is fault 5 and no further read is issued. If bits 31:0 of its third doubleword differ from bits 31:0 of the second list-entry doubleword, the result is fault 6.
- R7: An authority check runs when list-entry bit 56 is set and list-entry bits 47:32 differ from `cr_auth_i` bits 31:16 (the index). If index/16 exceeds the table length (bits 15:4 of the first second-level doubleword), the result is fault 7. Otherwise one byte is read at (bits 62:34)×4 + index/4. If that byte ANDed with 0x40 >> (2 × index bits 1:0) is zero, the result is fault 7. When the condition is false, no authority read is issued.
- R8: If list-entry bit 57 is set and the request is a write, the result is fault 8. Otherwise the result is fault 0 with `cw_o` equal to the second doubleword of the second-level entry.
- R9: Reads are strictly one at a time. `mem_req_o` stays high with `mem_addr_o` unchanged until `mem_ack_i`, and data is taken in the acknowledge cycle. Byte k of a doubleword sits in bits 63-8k:56-8k. The read count is 1 up to a designation fault, 2 up to a list-entry fault, 4 on a second-level invalid fault, 6 up to the sequence check, and 7 with an authority byte.
- R10: `done_o` is a one-cycle pulse. `fault_o` and `cw_o` hold until the next completion, and `cw_o` is zero whenever `fault_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken while idle |
| areg_i | input | 4 | Access-register number |
| token_i | input | 32 | Access-register token |
| wr_i | input | 1 | Request is a write |
| cr_prim_i | input | 64 | Primary control word |
| cr_sec_i | input | 64 | Secondary control word |
| cr_dsg_pub_i | input | 64 | Designation pointer for public tokens |
| cr_dsg_priv_i | input | 64 | Designation pointer for private tokens |
| cr_auth_i | input | 64 | Authorization control register, index in bits 31:16 |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read byte address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 64 | Doubleword containing the requested byte |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 4 | Fault code, 0 on success |
| cw_o | output | 64 | Resolved control word |

## Verification
The bound checker checks several things on every cycle. It checks the immediate completions: primary or secondary word, the reserved-bit fault, and the absence of reads in those cases. It checks the first designation address against the token's private bit, the stability of the read request until acknowledge, and the cleared control word on faults. The full read chain can only be shown by the bench's scenarios. Those scenarios cover each fault code at its point in the chain and the read counts that prove early abort. They also cover the 2-bit-stride authority bit selection across all byte lanes and index values, swept under several memory latencies.

// File: rtl/aspr_pkg.sv
package aspr_pkg;
  localparam int unsigned DW = 64;
  localparam int unsigned AW = 32;
  localparam int unsigned FW = 4;

  localparam logic [AW-1:0] DSG_MASK  = 32'h7FFF_FFC0;
  localparam logic [AW-1:0] DSG_OFS   = 32'd16;
  localparam logic [AW:0]   ADDR_LIM  = 33'h0_7FFF_FFFF;
  localparam logic [AW-1:0] DW_STEP   = 32'd8;

  typedef enum logic [FW-1:0] {
    FLT_NONE   = 4'd0,
    FLT_TOKEN  = 4'd1,
    FLT_ENTRY  = 4'd2,
    FLT_ADDR   = 4'd3,
    FLT_ESEQ   = 4'd4,
    FLT_SVALID = 4'd5,
    FLT_SSEQ   = 4'd6,
    FLT_AUTH   = 4'd7,
    FLT_PROT   = 4'd8
  } fault_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DSG, ST_E0, ST_E1, ST_S0, ST_S1, ST_S2, ST_AUTH
  } state_e;

  // list-entry fields kept after the first entry doubleword
  typedef struct packed {
    logic        fo;
    logic        prv;
    logic [15:0] aix;
  } ent_t;
endpackage

// File: rtl/aspr_entry_addr.sv
module aspr_entry_addr
  import aspr_pkg::*;
(
  input  logic [31:0]   dsg_word,
  input  logic [15:0]   entry_num,
  output logic [AW-1:0] entry_addr,
  output logic          len_fault,
  output logic          range_fault
);
  logic [23:0] org;
  logic [6:0]  len;
  logic [AW:0] sum;

  assign org = dsg_word[30:7];
  assign len = dsg_word[6:0];

  // full-width sum so that a carry past the 31-bit space is visible
  assign sum = {2'b00, org, 7'b0} + {13'b0, entry_num, 4'b0};

  assign len_fault   = entry_num[15:3] > {6'b0, len};
  assign range_fault = sum > ADDR_LIM;
  assign entry_addr  = sum[AW-1:0];

  logic unused_dsg;
  assign unused_dsg = dsg_word[31];
endmodule

// File: rtl/aspr_auth_sel.sv
module aspr_auth_sel
  import aspr_pkg::*;
(
  input  logic [28:0]   ato,
  input  logic [11:0]   atl,
  input  logic [15:0]   eax,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] auth_addr,
  output logic          over_fault,
  output logic          grant
);
  logic [5:0]    sh;
  logic [DW-1:0] shifted;
  logic [7:0]    sel_byte;
  logic [7:0]    mask;

  assign auth_addr  = {1'b0, ato, 2'b00} + {18'b0, eax[15:2]};
  assign over_fault = eax[15:4] > atl;

  // byte 0 of the doubleword is its most significant byte
  assign sh       = {3'(3'd7 - auth_addr[2:0]), 3'b000};
  assign shifted  = rdata >> sh;
  assign sel_byte = shifted[7:0];
  // two bits per index: the tested bit steps down by 2 for each index value
  assign mask     = 8'h40 >> {eax[1:0], 1'b0};
  assign grant    = |(sel_byte & mask);
endmodule

// File: rtl/aspace_resolver.sv
module aspace_resolver
  import aspr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    areg_i,
  input  logic [31:0]   token_i,
  input  logic          wr_i,
  input  logic [DW-1:0] cr_prim_i,
  input  logic [DW-1:0] cr_sec_i,
  input  logic [DW-1:0] cr_dsg_pub_i,
  input  logic [DW-1:0] cr_dsg_priv_i,
  input  logic [DW-1:0] cr_auth_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [FW-1:0] fault_o,
  output logic [DW-1:0] cw_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  state_e        state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [31:0]   tok_q, tok_d;
  logic          wr_q, wr_d;
  logic [15:0]   eax_q, eax_d;
  ent_t          ent_q, ent_d;
  logic [31:0]   sasn_q, sasn_d;
  logic [28:0]   ato_q, ato_d;
  logic [11:0]   atl_q, atl_d;
  logic [DW-1:0] cwt_q, cwt_d;
  logic          done_q, done_d;
  logic [FW-1:0] fault_q, fault_d;
  logic [DW-1:0] cw_q, cw_d;

  logic          idle_w;
  logic          ld_en;

  logic [AW-1:0] entry_addr;
  logic          len_fault, range_fault;
  logic [AW-1:0] auth_addr;
  logic          auth_over, auth_grant;

  aspr_entry_addr u_entry (
    .dsg_word   (mem_rdata_i[63:32]),
    .entry_num  (tok_q[15:0]),
    .entry_addr (entry_addr),
    .len_fault  (len_fault),
    .range_fault(range_fault)
  );

  aspr_auth_sel u_auth (
    .ato       (ato_q),
    .atl       (atl_q),
    .eax       (eax_q),
    .rdata     (mem_rdata_i),
    .auth_addr (auth_addr),
    .over_fault(auth_over),
    .grant     (auth_grant)
  );

  assign idle_w     = (state_q == ST_IDLE);
  assign mem_req_o  = !idle_w;
  assign mem_addr_o = addr_q;
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign cw_o       = cw_q;

  logic          fin;
  fault_e        fin_code;
  logic [DW-1:0] fin_cw;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    tok_d    = tok_q;
    wr_d     = wr_q;
    eax_d    = eax_q;
    ent_d    = ent_q;
    sasn_d   = sasn_q;
    ato_d    = ato_q;
    atl_d    = atl_q;
    cwt_d    = cwt_q;
    fin      = 1'b0;
    fin_code = FLT_NONE;
    fin_cw   = '0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (areg_i == 4'd0 || token_i == 32'd0) begin
            fin = 1'b1; fin_cw = cr_prim_i;
          end else if (token_i == 32'd1) begin
            fin = 1'b1; fin_cw = cr_sec_i;
          end else if (|token_i[31:25]) begin
            fin = 1'b1; fin_code = FLT_TOKEN;
          end else begin
            tok_d   = token_i;
            wr_d    = wr_i;
            eax_d   = cr_auth_i[31:16];
            addr_d  = ((token_i[24] ? cr_dsg_priv_i[31:0] : cr_dsg_pub_i[31:0])
                       & DSG_MASK) + DSG_OFS;
            state_d = ST_DSG;
          end
        end
      end
      ST_DSG: if (mem_ack_i) begin
        if (len_fault) begin
          fin = 1'b1; fin_code = FLT_ENTRY;
        end else if (range_fault) begin
          fin = 1'b1; fin_code = FLT_ADDR;
        end else begin
          addr_d  = entry_addr;
          state_d = ST_E0;
        end
      end
      ST_E0: if (mem_ack_i) begin
        if (mem_rdata_i[63]) begin
          fin = 1'b1; fin_code = FLT_ENTRY;
        end else if (mem_rdata_i[55:48] != tok_q[23:16]) begin
          fin = 1'b1; fin_code = FLT_ESEQ;
        end else begin
          ent_d.fo  = mem_rdata_i[57];
          ent_d.prv = mem_rdata_i[56];
          ent_d.aix = mem_rdata_i[47:32];
          addr_d    = addr_q + DW_STEP;
          state_d   = ST_E1;
        end
      end
      ST_E1: if (mem_ack_i) begin
        sasn_d  = mem_rdata_i[31:0];
        addr_d  = {1'b0, mem_rdata_i[62:38], 6'b0};
        state_d = ST_S0;
      end
      ST_S0: if (mem_ack_i) begin
        if (mem_rdata_i[63]) begin
          fin = 1'b1; fin_code = FLT_SVALID;
        end else begin
          ato_d   = mem_rdata_i[62:34];
          atl_d   = mem_rdata_i[15:4];
          addr_d  = addr_q + DW_STEP;
          state_d = ST_S1;
        end
      end
      ST_S1: if (mem_ack_i) begin
        cwt_d   = mem_rdata_i;
        addr_d  = addr_q + DW_STEP;
        state_d = ST_S2;
      end
      ST_S2: if (mem_ack_i) begin
        if (mem_rdata_i[31:0] != sasn_q) begin
          fin = 1'b1; fin_code = FLT_SSEQ;
        end else if (ent_q.prv && ent_q.aix != eax_q) begin
          if (auth_over) begin
            fin = 1'b1; fin_code = FLT_AUTH;
          end else begin
            addr_d  = auth_addr;
            state_d = ST_AUTH;
          end
        end else begin
          fin      = 1'b1;
          fin_code = (ent_q.fo && wr_q) ? FLT_PROT : FLT_NONE;
          fin_cw   = cwt_q;
        end
      end
      ST_AUTH: if (mem_ack_i) begin
        fin = 1'b1;
        if (!auth_grant) begin
          fin_code = FLT_AUTH;
        end else begin
          fin_code = (ent_q.fo && wr_q) ? FLT_PROT : FLT_NONE;
          fin_cw   = cwt_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    done_d  = fin;
    fault_d = fin ? fin_code : fault_q;
    cw_d    = fin ? ((fin_code == FLT_NONE) ? fin_cw : '0) : cw_q;
    if (fin) state_d = ST_IDLE;
  end

  // data registers load only on a start or an acknowledged read
  assign ld_en = (idle_w && start_i) || (!idle_w && mem_ack_i);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fault_q <= '0;
      cw_q    <= '0;
      addr_q  <= '0;
      tok_q   <= '0;
      wr_q    <= 1'b0;
      eax_q   <= '0;
      ent_q   <= '0;
      sasn_q  <= '0;
      ato_q   <= '0;
      atl_q   <= '0;
      cwt_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (ld_en) begin
        fault_q <= fault_d;
        cw_q    <= cw_d;
        addr_q  <= addr_d;
        tok_q   <= tok_d;
        wr_q    <= wr_d;
        eax_q   <= eax_d;
        ent_q   <= ent_d;
        sasn_q  <= sasn_d;
        ato_q   <= ato_d;
        atl_q   <= atl_d;
        cwt_q   <= cwt_d;
      end
    end
  end

  logic unused_cr;
  assign unused_cr = ^{cr_dsg_pub_i[63:32], cr_dsg_priv_i[63:32],
                       cr_auth_i[63:32], cr_auth_i[15:0]};
endmodule

// File: rtl/aspr_checker.sv
module aspr_checker
  import aspr_pkg::*;
(
  input logic          clk,
  input logic          rst_n_s,
  input logic          idle_w,
  input logic          start_i,
  input logic [3:0]    areg_i,
  input logic [31:0]   token_i,
  input logic [DW-1:0] cr_prim_i,
  input logic [DW-1:0] cr_sec_i,
  input logic [DW-1:0] cr_dsg_pub_i,
  input logic [DW-1:0] cr_dsg_priv_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic          done_o,
  input logic [FW-1:0] fault_o,
  input logic [DW-1:0] cw_o
);
  logic          take;
  logic [AW-1:0] exp_dsg;

  assign take    = start_i && idle_w;
  assign exp_dsg = ((token_i[24] ? cr_dsg_priv_i[31:0] : cr_dsg_pub_i[31:0])
                    & 32'h7FFF_FFC0) + 32'd16;

  assert_direct_prim_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    take && (areg_i == 4'd0 || token_i == 32'd0)
    |=> done_o && fault_o == 4'd0 && cw_o == $past(cr_prim_i) && !mem_req_o);

  assert_direct_sec_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    take && areg_i != 4'd0 && token_i == 32'd1
    |=> done_o && fault_o == 4'd0 && cw_o == $past(cr_sec_i) && !mem_req_o);

  assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    take && areg_i != 4'd0 && token_i > 32'd1 && token_i[31:25] != 7'd0
    |=> done_o && fault_o == 4'd1 && !mem_req_o);

  assert_first_read_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    take && areg_i != 4'd0 && token_i > 32'd1 && token_i[31:25] == 7'd0
    |=> mem_req_o && !done_o && mem_addr_o == $past(exp_dsg));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  assert_done_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !mem_req_o);

  assert_fault_clears_cw_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o && fault_o != 4'd0 |-> cw_o == '0);

  assert_fault_range_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> fault_o <= 4'd8);
endmodule

bind aspace_resolver aspr_checker u_chk (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .idle_w       (idle_w),
  .start_i      (start_i),
  .areg_i       (areg_i),
  .token_i      (token_i),
  .cr_prim_i    (cr_prim_i),
  .cr_sec_i     (cr_sec_i),
  .cr_dsg_pub_i (cr_dsg_pub_i),
  .cr_dsg_priv_i(cr_dsg_priv_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .cw_o         (cw_o)
);

// File: tb/tb_aspace_resolver.sv
`timescale 1ns/1ps
module tb_aspace_resolver;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [3:0]  areg_i;
  logic [31:0] token_i;
  logic        wr_i;
  logic [63:0] cr_prim_i, cr_sec_i, cr_dsg_pub_i, cr_dsg_priv_i, cr_auth_i;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i;
  logic [63:0] mem_rdata_i;
  logic        done_o;
  logic [3:0]  fault_o;
  logic [63:0] cw_o;

  always #4 clk = ~clk;

  aspace_resolver dut (
    .clk(clk), .rst_ni(rst_ni), .start_i(start_i), .areg_i(areg_i),
    .token_i(token_i), .wr_i(wr_i), .cr_prim_i(cr_prim_i), .cr_sec_i(cr_sec_i),
    .cr_dsg_pub_i(cr_dsg_pub_i), .cr_dsg_priv_i(cr_dsg_priv_i),
    .cr_auth_i(cr_auth_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .done_o(done_o),
    .fault_o(fault_o), .cw_o(cw_o)
  );

  logic [63:0] mem [int unsigned];
  int checks = 0, fails = 0, acks = 0, lat = 0;

  function automatic logic [63:0] rdw(input logic [31:0] a);
    int unsigned k = int'(a >> 3);
    if (mem.exists(k)) return mem[k];
    return 64'h0;
  endfunction

  task automatic wrw(input logic [31:0] a, input logic [63:0] d);
    mem[int'(a >> 3)] = d;
  endtask

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: one read at a time, programmable latency
  initial begin
    int wc = 0;
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o) begin
        if (wc >= lat) begin
          mem_ack_i = 1'b1;
          mem_rdata_i = rdw(mem_addr_o);
          acks++;
          wc = 0;
        end else wc++;
      end
    end
  end

  // reference model written from the requirements
  function automatic void model(input logic [3:0] ar, input logic [31:0] tok, input bit wr,
                                output logic [3:0] f, output logic [63:0] cw, output int nrd);
    logic [31:0] da, dw, sa, ba;
    logic [32:0] sum;
    logic [63:0] e0, e1, s0, s1, s2, bd;
    logic [15:0] ex;
    logic [7:0]  by;
    f = 4'd0; cw = '0; nrd = 0;
    if (ar == 0 || tok == 0) begin cw = cr_prim_i; return; end
    if (tok == 1) begin cw = cr_sec_i; return; end
    if (tok[31:25] != 0) begin f = 4'd1; return; end
    da = ((tok[24] ? cr_dsg_priv_i[31:0] : cr_dsg_pub_i[31:0]) & 32'h7FFFFFC0) + 32'd16;
    bd = rdw(da); dw = bd[63:32]; nrd = 1;
    if ((tok[15:0] / 8) > {9'b0, dw[6:0]}) begin f = 4'd2; return; end
    sum = 33'(dw[30:7]) * 33'd128 + 33'(tok[15:0]) * 33'd16;
    if (sum > 33'h7FFFFFFF) begin f = 4'd3; return; end
    e0 = rdw(sum[31:0]); nrd = 2;
    if (e0[63]) begin f = 4'd2; return; end
    if (e0[55:48] != tok[23:16]) begin f = 4'd4; return; end
    e1 = rdw(sum[31:0] + 32'd8); nrd = 3;
    sa = 32'(e1[62:38]) * 32'd64;
    s0 = rdw(sa); nrd = 4;
    if (s0[63]) begin f = 4'd5; return; end
    s1 = rdw(sa + 32'd8); s2 = rdw(sa + 32'd16); nrd = 6;
    if (s2[31:0] != e1[31:0]) begin f = 4'd6; return; end
    ex = cr_auth_i[31:16];
    if (e0[56] && e0[47:32] != ex) begin
      if ((ex / 16) > {4'b0, s0[15:4]}) begin f = 4'd7; return; end
      ba = 32'(s0[62:34]) * 32'd4 + 32'(ex / 4);
      bd = rdw(ba); nrd = 7;
      by = 8'(bd >> (8 * (7 - int'(ba[2:0]))));
      if ((by & (8'h40 >> (2 * (ex % 4)))) == 0) begin f = 4'd7; return; end
    end
    if (e0[57] && wr) begin f = 4'd8; return; end
    cw = s1;
  endfunction

  task automatic run(input logic [3:0] ar, input logic [31:0] tok, input bit wr,
                     output logic [3:0] f, output logic [63:0] cw, output int nrd, output bit to);
    int n = 0;
    acks = 0;
    @(negedge clk);
    areg_i = ar; token_i = tok; wr_i = wr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && n < 300) begin @(negedge clk); n++; end
    to = !done_o;
    f = fault_o; cw = cw_o; nrd = acks;
  endtask

  localparam logic [31:0] PUB_BASE  = 32'h0001_2350;
  localparam logic [31:0] PRIV_BASE = 32'h0002_0010;
  localparam logic [31:0] SECT_BASE = 32'h0001_0000;

  // builds one complete table chain; v selects which check is broken
  task automatic build(input int v, input bit priv, input logic [15:0] eax, input int bit_sel);
    logic [23:0] org = 24'h000100;
    logic [6:0]  len = 7'd4;
    logic [15:0] alen = 16'h0023;
    logic [31:0] ea, ba;
    logic [11:0] atl = (v == 4) ? 12'd3 : 12'd4;
    logic [15:0] aix = (v == 1) ? eax : 16'h0099;
    logic [7:0]  good, lane;
    mem.delete();
    if (v == 5) len = 7'd3;
    if (v == 6) begin org = 24'hFFFFFF; len = 7'h7F; end
    cr_auth_i = {32'h0, eax, 16'h1234};
    token_i = {7'b0, priv, 8'h5A, alen};
    wrw(priv ? PRIV_BASE : PUB_BASE, {1'b0, org, len, 32'h1357_9BDF});
    wrw(priv ? PUB_BASE : PRIV_BASE, {1'b0, org, 7'd0, 32'h0});  // decoy, length 0
    ea = {1'b0, org, 7'b0} + {12'b0, alen, 4'b0};
    wrw(ea, {(v == 7), 5'b0, (v == 11), (v >= 1 && v <= 4), (v == 8) ? 8'h5B : 8'h5A,
             aix, 32'hFFFF_FFFF});
    wrw(ea + 8, {1'b0, 25'h400, 6'b0, 32'hC0FF_EE01});
    wrw(SECT_BASE, {(v == 9), 29'h1800, 1'b0, 1'b1, 16'h7777, atl, 4'b0011});
    wrw(SECT_BASE + 8, 64'hA5A5_0000_1234_0000 + 64'(v));
    wrw(SECT_BASE + 16, {32'h0BAD_F00D, (v == 10) ? 32'hC0FF_EE02 : 32'hC0FF_EE01});
    ba = 32'h6000 + 32'(eax >> 2);
    good = 8'h40 >> (2 * (eax % 4));
    lane = (bit_sel >= 0) ? 8'(1 << bit_sel) : ((v == 3) ? ~good : good);
    begin
      logic [63:0] d = '0;
      for (int k = 0; k < 8; k++) d[63 - 8*k -: 8] = (k == int'(ba[2:0])) ? lane : ~lane;
      wrw(ba, d);
    end
  endtask

  function automatic string vtag(input int v);
    case (v)
      3, 4: return "R7";
      5, 6: return "R4";
      7, 8: return "R5";
      9, 10: return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] f, ef;
    logic [63:0] cw, ecw;
    int nrd, enrd;
    bit to;
    start_i = 0; areg_i = 0; token_i = 0; wr_i = 0;
    cr_prim_i = 64'h1111_2222_3333_4444;
    cr_sec_i  = 64'h5555_6666_7777_8888;
    cr_dsg_pub_i  = 64'hFFFF_0000_8001_2377;
    cr_dsg_priv_i = 64'h0000_0000_0002_0005;
    cr_auth_i = '0;
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    chk("R10 reset done", done_o == 0, 64'(done_o), 0);
    chk("R9 reset req", mem_req_o == 0, 64'(mem_req_o), 0);
    chk("R10 reset fault", fault_o == 0, 64'(fault_o), 0);

    // R1 direct sweep over register numbers and the two special tokens
    for (int ar = 0; ar < 16; ar++) begin
      for (int t = 0; t < 2; t++) begin
        run(4'(ar), 32'(t), 1'b1, f, cw, nrd, to);
        ecw = (ar == 0 || t == 0) ? cr_prim_i : cr_sec_i;
        chk("R1 direct word", !to && f == 0 && cw == ecw, cw, ecw);
        chk("R1 no read", nrd == 0, 64'(nrd), 0);
      end
    end
    // R1 priority: register 0 wins over a reserved-bit token
    run(4'd0, 32'h8001_0023, 1'b0, f, cw, nrd, to);
    chk("R1 reg0 priority", f == 0 && cw == cr_prim_i, cw, cr_prim_i);

    // R2 each reserved bit alone
    for (int b = 25; b < 32; b++) begin
      run(4'd3, (32'd1 << b) | 32'h0001_0023, 1'b0, f, cw, nrd, to);
      chk("R2 token fault", !to && f == 4'd1 && cw == 0, 64'(f), 64'd1);
      chk("R2 no read", nrd == 0, 64'(nrd), 0);
    end

    // main sweep: every broken check, both list pointers, read/write, latencies
    for (int v = 0; v < 12; v++)
      for (int pv = 0; pv < 2; pv++)
        for (int w = 0; w < 2; w++)
          for (int l = 0; l < 3; l++) begin
            lat = l;
            build(v, pv[0], 16'h0045, -1);
            model(4'd5, token_i, w[0], ef, ecw, enrd);
            run(4'd5, token_i, w[0], f, cw, nrd, to);
            chk({vtag(v), " fault code"}, !to && f == ef, 64'(f), 64'(ef));
            chk({vtag(v), " control word"}, cw == ecw, cw, ecw);
            chk("R9 read count", nrd == enrd, 64'(nrd), 64'(enrd));
            if (v == 0 && w == 0) chk("R3 designation select", f == 0, 64'(f), 0);
          end
    lat = 0;

    // R7 authority bit selection: all index values up to 31, every bit position
    for (int e = 0; e < 32; e++)
      for (int b = 0; b < 8; b++) begin
        build(2, 1'b0, 16'(e), b);
        model(4'd7, token_i, 1'b0, ef, ecw, enrd);
        run(4'd7, token_i, 1'b0, f, cw, nrd, to);
        chk("R7 authority bit", !to && f == ef && cw == ecw, 64'(f), 64'(ef));
        chk("R7 authority read", nrd == enrd, 64'(nrd), 64'(enrd));
      end

    // R10 result holds and done is a single pulse
    build(0, 1'b1, 16'h0045, -1);
    run(4'd2, token_i, 1'b0, f, cw, nrd, to);
    repeat (3) @(negedge clk);
    chk("R10 done pulse", done_o == 0, 64'(done_o), 0);
    chk("R10 word held", cw_o == cw && fault_o == f, cw_o, cw);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule